// File: doc/BRIEF.md
# Trap Entry Sequencer for a Register-Windowed Processor

This block computes the architectural state change that a register-windowed 32-bit processor makes when it accepts a trap. The core presents a request with an 8-bit trap number together with its current status bits, window pointer, program counters, trap base register and cache control field. One clock later the block presents the complete new state as a single committed update. That update covers the status bits, the rotated window pointer, two register-file writes that save the old program counters, the rewritten trap base register, the redirected fetch address and the cache control field.

When traps are already disabled at the moment a request arrives, the trap is not taken. The block instead halts in a terminal error state. If the optional shutdown feature is configured, software trap 0x80 in this condition raises a shutdown request instead of the error. Trap numbers in the external-interrupt group cause a one-cycle acknowledge that carries the trap number back to the interrupt controller. When their freeze flags are set, an enabled instruction cache or data cache is marked as frozen.

Top module: `trap_entry_seq`

## Requirements
- R1: A request accepted while `cur_et` is 0 produces no commit. It sets `error_halt`, which then stays at 1 and keeps `busy` at 1 until reset, so that every later request is ignored. The exception is the case covered by R2.
- R2: When `SHUTDOWN_TA0` is 1, a request with trap number 0x80 accepted while `cur_et` is 0 sets the sticky `shutdown_req` instead of `error_halt`, with no commit. Trap number 0x81 in the same condition still goes to R1.
- R3: On commit, `new_et` is 0, `new_s` is 1 and `new_ps` equals the `cur_s` value that was sampled with the request.
- R4: On commit, `new_cwp` equals `cur_cwp` minus 1 modulo `NWIN`, so window 0 becomes `NWIN-1`.
- R5: On commit, `rf_we` is 1. Write port A carries index 17 with the old PC, and write port B carries index 18 with the old nPC.
- R6: On commit, `new_tbr` keeps bits 31:12 of `cur_tbr`, holds the trap number in bits 11:4 and has bits 3:0 at zero.
- R7: On commit, `new_pc` equals `new_tbr` and `new_npc` equals `new_tbr + 4`.
- R8: `irq_ack` pulses together with commit exactly when bits 7:4 of the trap number are 4'h1, and `irq_tt` then carries the full trap number.
- R9: Bits 1:0 of the cache field hold the instruction-cache state, where 2'b11 means enabled and 2'b01 means frozen. When `icache_frz` is 1 and this state is 2'b11, the committed value is 2'b01. In every other case the bits pass through unchanged.
- R10: Bits 3:2 hold the data-cache state, using the same encodings under `dcache_frz`. The data-cache field is handled independently of the instruction-cache field.
- R11: `commit` pulses for exactly one cycle, in the cycle after the edge that accepts a request. `busy` is 1 during that cycle, and a request presented while `busy` is 1 is ignored.
- R12: After reset, `commit`, `rf_we`, `irq_ack`, `busy`, `error_halt` and `shutdown_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request, accepted when busy is low |
| trap_tt | input | 8 | Trap number |
| cur_et | input | 1 | Current enable-traps bit |
| cur_s | input | 1 | Current supervisor bit |
| cur_cwp | input | CWPW | Current window pointer |
| cur_pc | input | 32 | Current program counter |
| cur_npc | input | 32 | Current next program counter |
| cur_tbr | input | 32 | Current trap base register |
| cur_cache | input | 4 | Cache state field: instruction cache in 1:0, data cache in 3:2 |
| icache_frz | input | 1 | Freeze the instruction cache on interrupt |
| dcache_frz | input | 1 | Freeze the data cache on interrupt |
| busy | output | 1 | Request is held off (commit cycle or halted) |
| commit | output | 1 | New state below is valid this cycle |
| new_et | output | 1 | Enable-traps bit after entry |
| new_s | output | 1 | Supervisor bit after entry |
| new_ps | output | 1 | Previous-supervisor bit after entry |
| new_cwp | output | CWPW | Window pointer after entry |
| rf_we | output | 1 | Register-file write enable for both ports |
| rf_a_idx | output | 5 | Write port A register index (17) |
| rf_a_data | output | 32 | Write port A data (old PC) |
| rf_b_idx | output | 5 | Write port B register index (18) |
| rf_b_data | output | 32 | Write port B data (old nPC) |
| new_tbr | output | 32 | Trap base register after entry |
| new_pc | output | 32 | Fetch address after entry |
| new_npc | output | 32 | Next fetch address after entry |
| new_cache | output | 4 | Cache state field after entry |
| irq_ack | output | 1 | External-interrupt acknowledge pulse |
| irq_tt | output | 8 | Trap number being acknowledged |
| error_halt | output | 1 | Sticky error state |
| shutdown_req | output | 1 | Sticky shutdown request |

## Verification
The hardest situations to reach are the two terminal halts. Once either halt is entered, nothing more can be observed until reset, so each one is reached in its own reset episode. In each episode a single request is made with enable-traps low, then a legal request with enable-traps high is made to show that it is ignored. Outside the halts, one sweep goes through all 256 trap numbers with enable-traps high. Along the way it steps the window pointer through every window including the wrap from 0, every cache state value under all four freeze-flag combinations, and both sides of the interrupt group. A request held high across the commit cycle shows the hold-off behaviour.

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int NWIN = 8,
  parameter bit SHUTDOWN_TA0 = 1'b1,
  localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_req,
  input  logic [7:0]      trap_tt,
  input  logic            cur_et,
  input  logic            cur_s,
  input  logic [CWPW-1:0] cur_cwp,
  input  logic [31:0]     cur_pc,
  input  logic [31:0]     cur_npc,
  input  logic [31:0]     cur_tbr,
  input  logic [3:0]      cur_cache,
  input  logic            icache_frz,
  input  logic            dcache_frz,
  output logic            busy,
  output logic            commit,
  output logic            new_et,
  output logic            new_s,
  output logic            new_ps,
  output logic [CWPW-1:0] new_cwp,
  output logic            rf_we,
  output logic [4:0]      rf_a_idx,
  output logic [31:0]     rf_a_data,
  output logic [4:0]      rf_b_idx,
  output logic [31:0]     rf_b_data,
  output logic [31:0]     new_tbr,
  output logic [31:0]     new_pc,
  output logic [31:0]     new_npc,
  output logic [3:0]      new_cache,
  output logic            irq_ack,
  output logic [7:0]      irq_tt,
  output logic            error_halt,
  output logic            shutdown_req
);

  localparam logic [1:0] C_ON  = 2'b11;
  localparam logic [1:0] C_FRZ = 2'b01;
  localparam logic [CWPW-1:0] LAST_WIN = CWPW'(NWIN - 1);

  logic accept, take, to_shut;
  logic [CWPW-1:0] cwp_dec;
  logic [31:0] tbr_nx;
  logic [1:0] ic_nx, dc_nx;

  assign busy    = commit | error_halt | shutdown_req;
  assign accept  = trap_req & ~busy;
  assign take    = accept & cur_et;
  assign to_shut = SHUTDOWN_TA0 && trap_tt == 8'h80;

  assign cwp_dec = (cur_cwp == '0) ? LAST_WIN : cur_cwp - 1'b1;
  assign tbr_nx  = {cur_tbr[31:12], trap_tt, 4'h0};
  assign ic_nx   = (icache_frz && cur_cache[1:0] == C_ON) ? C_FRZ : cur_cache[1:0];
  assign dc_nx   = (dcache_frz && cur_cache[3:2] == C_ON) ? C_FRZ : cur_cache[3:2];

  assign rf_we    = commit;
  assign rf_a_idx = 5'd17;
  assign rf_b_idx = 5'd18;
  assign new_npc  = new_pc + 32'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit       <= 1'b0;
      irq_ack      <= 1'b0;
      error_halt   <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      commit  <= take;
      irq_ack <= take && trap_tt[7:4] == 4'h1;
      if (accept && !cur_et) begin
        if (to_shut) shutdown_req <= 1'b1;
        else         error_halt   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_et    <= 1'b0;
      new_s     <= 1'b0;
      new_ps    <= 1'b0;
      new_cwp   <= '0;
      rf_a_data <= '0;
      rf_b_data <= '0;
      new_tbr   <= '0;
      new_pc    <= '0;
      new_cache <= '0;
      irq_tt    <= '0;
    end else if (take) begin
      new_et    <= 1'b0;
      new_s     <= 1'b1;
      new_ps    <= cur_s;
      new_cwp   <= cwp_dec;
      rf_a_data <= cur_pc;
      rf_b_data <= cur_npc;
      new_tbr   <= tbr_nx;
      new_pc    <= tbr_nx;
      new_cache <= {dc_nx, ic_nx};
      irq_tt    <= trap_tt;
    end
  end

  p_halt_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    error_halt |=> error_halt && !commit);
  p_shut_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> shutdown_req && !commit);
  p_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !new_et && new_s && new_ps == $past(cur_s));
  p_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> new_pc == new_tbr && new_npc == new_tbr + 32'd4);
  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> commit && irq_tt[7:4] == 4'h1);
  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  p_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit) |-> $past(trap_req) && $past(cur_et));
  p_freeze_ic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit && $past(icache_frz) |-> new_cache[1:0] != C_ON);

endmodule

// File: tb/test_trap_entry_seq.sv
module test_trap_entry_seq;
  localparam int NWIN = 8;
  localparam int CWPW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 1'b0;
  logic [7:0] trap_tt = '0;
  logic cur_et = 1'b1, cur_s = 1'b0;
  logic [CWPW-1:0] cur_cwp = '0;
  logic [31:0] cur_pc = '0, cur_npc = '0, cur_tbr = '0;
  logic [3:0] cur_cache = '0;
  logic icache_frz = 1'b0, dcache_frz = 1'b0;
  logic busy, commit, new_et, new_s, new_ps, rf_we, irq_ack, error_halt, shutdown_req;
  logic [CWPW-1:0] new_cwp;
  logic [4:0] rf_a_idx, rf_b_idx;
  logic [31:0] rf_a_data, rf_b_data, new_tbr, new_pc, new_npc;
  logic [3:0] new_cache;
  logic [7:0] irq_tt;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  trap_entry_seq #(.NWIN(NWIN), .SHUTDOWN_TA0(1'b1)) i_trap_entry_seq (
    .clk, .rst_n, .trap_req, .trap_tt, .cur_et, .cur_s, .cur_cwp, .cur_pc,
    .cur_npc, .cur_tbr, .cur_cache, .icache_frz, .dcache_frz, .busy, .commit,
    .new_et, .new_s, .new_ps, .new_cwp, .rf_we, .rf_a_idx, .rf_a_data,
    .rf_b_idx, .rf_b_data, .new_tbr, .new_pc, .new_npc, .new_cache, .irq_ack,
    .irq_tt, .error_halt, .shutdown_req);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] frz(input logic f, input logic [1:0] st);
    return (f && st == 2'b11) ? 2'b01 : st;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; trap_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    chk("R12 commit", commit, 0);
    chk("R12 rf_we", rf_we, 0);
    chk("R12 irq_ack", irq_ack, 0);
    chk("R12 busy", busy, 0);
    chk("R12 error_halt", error_halt, 0);
    chk("R12 shutdown_req", shutdown_req, 0);

    for (int i = 0; i < 256; i++) begin
      logic [31:0] etbr;
      logic [CWPW-1:0] ecwp;
      logic [3:0] ec;
      @(negedge clk);
      trap_req = 1'b1; trap_tt = 8'(i); cur_et = 1'b1;
      cur_s = i[3]; cur_cwp = CWPW'(i % NWIN);
      cur_pc = 32'h4000_0000 + 32'(i) * 32'd8;
      cur_npc = 32'h5000_0004 + 32'(i) * 32'd12;
      cur_tbr = (32'hABCDE000 ^ (32'(i) << 12)) | 32'h0000_0FF5;
      cur_cache = 4'(i); icache_frz = i[4]; dcache_frz = i[5];
      chk("R11 idle busy", busy, 0);
      @(negedge clk);
      trap_req = 1'b0;
      etbr = {cur_tbr[31:12], 8'(i), 4'h0};
      ecwp = (cur_cwp == 0) ? CWPW'(NWIN - 1) : cur_cwp - 1'b1;
      ec = {frz(dcache_frz, cur_cache[3:2]), frz(icache_frz, cur_cache[1:0])};
      chk("R11 commit", commit, 1);
      chk("R11 busy", busy, 1);
      chk("R3 et", new_et, 0);
      chk("R3 s", new_s, 1);
      chk("R3 ps", new_ps, cur_s);
      chk("R4 cwp", new_cwp, ecwp);
      chk("R5 we", rf_we, 1);
      chk("R5 a_idx", rf_a_idx, 17);
      chk("R5 a_data", rf_a_data, cur_pc);
      chk("R5 b_idx", rf_b_idx, 18);
      chk("R5 b_data", rf_b_data, cur_npc);
      chk("R6 tbr", new_tbr, etbr);
      chk("R7 pc", new_pc, etbr);
      chk("R7 npc", new_npc, etbr + 4);
      chk("R8 ack", irq_ack, (i >> 4) == 1);
      if ((i >> 4) == 1) chk("R8 irq_tt", irq_tt, i);
      chk("R9 icache", new_cache[1:0], ec[1:0]);
      chk("R10 dcache", new_cache[3:2], ec[3:2]);
      @(negedge clk);
      chk("R11 single pulse", commit, 0);
      chk("R8 ack pulse", irq_ack, 0);
    end

    // R11 request held across the commit cycle is ignored there
    @(negedge clk);
    trap_req = 1'b1; trap_tt = 8'h05; cur_cwp = 3'd4;
    @(negedge clk);
    chk("R11 held first commit", commit, 1);
    trap_tt = 8'h12; cur_cwp = 3'd2;
    @(negedge clk);
    chk("R11 held ignored", commit, 0);
    chk("R11 held irq_ack", irq_ack, 0);
    @(negedge clk);
    trap_req = 1'b0;
    chk("R11 reaccept", commit, 1);
    chk("R11 reaccept cwp", new_cwp, 1);
    chk("R8 reaccept ack", irq_ack, 1);

    // R1 error halt
    do_reset();
    trap_req = 1'b1; trap_tt = 8'h05; cur_et = 1'b0;
    @(negedge clk);
    trap_req = 1'b0;
    chk("R1 no commit", commit, 0);
    chk("R1 error_halt", error_halt, 1);
    chk("R1 busy", busy, 1);
    chk("R1 no shutdown", shutdown_req, 0);
    trap_req = 1'b1; cur_et = 1'b1; trap_tt = 8'h11;
    @(negedge clk);
    @(negedge clk);
    trap_req = 1'b0;
    chk("R1 later ignored", commit, 0);
    chk("R1 later no ack", irq_ack, 0);
    chk("R1 sticky", error_halt, 1);

    // R2 shutdown on 0x80
    do_reset();
    trap_req = 1'b1; trap_tt = 8'h80; cur_et = 1'b0;
    @(negedge clk);
    trap_req = 1'b0;
    chk("R2 shutdown", shutdown_req, 1);
    chk("R2 no error", error_halt, 0);
    chk("R2 no commit", commit, 0);
    chk("R2 busy", busy, 1);
    trap_req = 1'b1; cur_et = 1'b1; trap_tt = 8'h03;
    @(negedge clk);
    trap_req = 1'b0;
    chk("R2 later ignored", commit, 0);
    chk("R2 sticky", shutdown_req, 1);

    // R2 trap 0x81 still errors
    do_reset();
    trap_req = 1'b1; trap_tt = 8'h81; cur_et = 1'b0;
    @(negedge clk);
    trap_req = 1'b0;
    chk("R2 0x81 error", error_halt, 1);
    chk("R2 0x81 no shutdown", shutdown_req, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule